// File: doc/BRIEF.md
# Autocorrelation Packet-Start Detector

This block watches a stream of complex baseband samples for the start of an OFDM packet. A packet's short training part is ten copies of a 16-sample pattern, 160 samples in all. The detector correlates each span of L samples with the L samples that follow it. L is half of that training length, 80 by default. It also measures the energy of the later span. When the squared correlation magnitude exceeds half of the squared energy, the detector flags a packet start. It records the window start index at which the test passed.

The correlation P and the energy R are kept as running sums. Each new sample adds one term and removes the term that has left the window, so a fresh (P, R) pair exists for every window position. Only selected positions are tested. The first is position 0. After each miss, the next position tested is the previous one plus a programmable hop.

In two-chain mode, the correlation and energy of two receive chains are summed before the test. The test is homogeneous in P and R, so this equals averaging them. Sample indices count accepted samples from reset or from the last clear.

Top module: `acorr_pkt_det`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, `det` is 0 and `det_idx` is 0. The sample index restarts, so the next accepted sample has index 0.
- R2: Window d covers sample indices d to d+2L-1, where L = `LAG`. P[d] is the sum over m = 0..L-1 of conj(r[d+m])·r[d+m+L]. R[d] is the sum over m = 0..L-1 of |r[d+m+L]|². On detection, `det_idx` reports d.
- R3: No window is tested before 2L samples have been accepted. The first window tested is d = 0, once sample 2L-1 is accepted.
- R4: A tested window hits exactly when 2·(Re(P)² + Im(P)²) > R², evaluated without loss. Equality is a miss, so an all-zero stream never hits.
- R5: After a miss at window d, the next window tested is d+`hop`, and windows in between are skipped. A `hop` of 0 behaves as 1.
- R6: With `dual_mode` = 1, P and R are the sums of chain 0 (`c0_*`) and chain 1 (`c1_*`) before the test. With `dual_mode` = 0, the chain 1 inputs have no effect.
- R7: Once set, `det` stays 1 and `det_idx` holds until `clr`. No further windows are tested.
- R8: `det` rises on the clock edge that follows the edge accepting sample d+2L-1 of the hitting window.
- R9: A cycle with `in_valid` = 0 accepts no sample and changes no window.
- R10: `clr` takes priority over `in_valid`. A sample presented in a clear cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous restart of the search and of the sample index |
| in_valid | input | 1 | A sample is presented this cycle |
| dual_mode | input | 1 | 1: combine both receive chains |
| hop | input | HW (8) | Window advance after a miss |
| c0_re | input | SW (12) | Chain 0 sample, real part, signed |
| c0_im | input | SW (12) | Chain 0 sample, imaginary part, signed |
| c1_re | input | SW (12) | Chain 1 sample, real part, signed |
| c1_im | input | SW (12) | Chain 1 sample, imaginary part, signed |
| det | output | 1 | Packet start found (sticky) |
| det_idx | output | IW (16) | Window start index of the detection |

## Verification
The checker assumes that `clr` and reset are driven synchronously to the clock. It also assumes that a search ends before the sample count saturates, that is, in fewer than 2^IW samples. It takes `hop` and `dual_mode` to be steady while a search runs, since the stated detection index depends on their value when each window is tested. The bench keeps every case under 1024 samples and clears between cases. It changes `hop` and `dual_mode` only while cleared. Sample amplitudes stay far enough below full scale that its 64-bit reference sums stay exact.

// File: rtl/adt_pkg.sv
package adt_pkg;

   // width of an exact sum of `terms` values of `term_w` bits each
   function automatic int acc_width(input int term_w, input int terms);
      return term_w + $clog2(terms);
   endfunction

   typedef enum logic {
      CHAIN_SOLO = 1'b0,
      CHAIN_PAIR = 1'b1
   } chain_mode_e;

endpackage

// File: rtl/adt_delay.sv
// Sample history of 2*HALF entries with taps at HALF and 2*HALF samples back.
module adt_delay #(
   parameter int W    = 24,
   parameter int HALF = 80
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic [W-1:0] tap_half,
   output logic [W-1:0] tap_full
);
   localparam int DEPTH = 2 * HALF;

   logic [W-1:0] line [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) line[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < DEPTH; i++) line[i] <= '0;
      end else if (shift) begin
         line[0] <= din;
         for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
      end
   end

   // before the shift, line[k] holds the sample k+1 positions back
   assign tap_half = line[HALF-1];
   assign tap_full = line[DEPTH-1];

endmodule

// File: rtl/adt_corr_chain.sv
// Running lag-HALF correlation and delayed-half energy for one receive chain.
module adt_corr_chain #(
   parameter int SW   = 12,
   parameter int HALF = 80,
   parameter int PW   = 32,
   parameter int RW   = 31
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 shift,
   input  logic signed [SW-1:0] s_re,
   input  logic signed [SW-1:0] s_im,
   output logic signed [PW-1:0] p_re,
   output logic signed [PW-1:0] p_im,
   output logic        [RW-1:0] r_en
);
   localparam int TW = 2 * SW + 1;

   logic [2*SW-1:0] h_pack, f_pack;

   adt_delay #(.W(2*SW), .HALF(HALF)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .shift    (shift),
      .din      ({s_re, s_im}),
      .tap_half (h_pack),
      .tap_full (f_pack)
   );

   // operands widened to term width so every product is exact
   logic signed [TW-1:0] nr, ni, hr, hi, fr, fi;
   assign nr = TW'(s_re);
   assign ni = TW'(s_im);
   assign hr = TW'($signed(h_pack[2*SW-1:SW]));
   assign hi = TW'($signed(h_pack[SW-1:0]));
   assign fr = TW'($signed(f_pack[2*SW-1:SW]));
   assign fi = TW'($signed(f_pack[SW-1:0]));

   logic signed [TW-1:0] add_re, add_im, sub_re, sub_im, add_e, sub_e;
   always_comb begin
      // entering term: conj(r[n-L]) * r[n]
      add_re = hr * nr + hi * ni;
      add_im = hr * ni - hi * nr;
      // leaving term: conj(r[n-2L]) * r[n-L]
      sub_re = fr * hr + fi * hi;
      sub_im = fr * hi - fi * hr;
      add_e  = nr * nr + ni * ni;
      sub_e  = hr * hr + hi * hi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_re <= '0;
         p_im <= '0;
         r_en <= '0;
      end else if (clr) begin
         p_re <= '0;
         p_im <= '0;
         r_en <= '0;
      end else if (shift) begin
         p_re <= p_re + PW'(add_re) - PW'(sub_re);
         p_im <= p_im + PW'(add_im) - PW'(sub_im);
         r_en <= r_en + RW'($unsigned(add_e)) - RW'($unsigned(sub_e));
      end
   end

endmodule

// File: rtl/adt_decide.sv
// Exact threshold test and hop scheduling of the tested window positions.
module adt_decide #(
   parameter int CPW = 33,
   parameter int CRW = 32,
   parameter int IW  = 16,
   parameter int HW  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  upd,
   input  logic                  full,
   input  logic        [IW-1:0]  widx,
   input  logic signed [CPW-1:0] p_re,
   input  logic signed [CPW-1:0] p_im,
   input  logic        [CRW-1:0] r_en,
   input  logic        [HW-1:0]  hop,
   output logic                  det,
   output logic        [IW-1:0]  det_idx
);
   localparam int QW   = 2 * CPW + 1;
   localparam int CMPW = (QW > 2 * CRW) ? QW : 2 * CRW;

   logic signed [CMPW-1:0] xr, xi;
   logic        [CMPW-1:0] xe, mag2, lhs, rhs;
   logic                   hit, eval;
   logic        [IW-1:0]   next_d, step;

   always_comb begin
      xr   = CMPW'(p_re);
      xi   = CMPW'(p_im);
      xe   = CMPW'(r_en);
      mag2 = $unsigned(xr * xr + xi * xi);
      lhs  = mag2 << 1;
      rhs  = xe * xe;
      hit  = lhs > rhs;
      step = (hop == '0) ? IW'(1) : IW'(hop);
      eval = upd && full && !det && (widx == next_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         det     <= 1'b0;
         det_idx <= '0;
         next_d  <= '0;
      end else if (clr) begin
         det     <= 1'b0;
         det_idx <= '0;
         next_d  <= '0;
      end else if (eval) begin
         if (hit) begin
            det     <= 1'b1;
            det_idx <= widx;
         end else begin
            next_d  <= next_d + step;
         end
      end
   end

endmodule

// File: rtl/acorr_pkt_det.sv
module acorr_pkt_det
   import adt_pkg::*;
#(
   parameter int SW  = 12,
   parameter int LAG = 80,
   parameter int IW  = 16,
   parameter int HW  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 in_valid,
   input  logic                 dual_mode,
   input  logic [HW-1:0]        hop,
   input  logic signed [SW-1:0] c0_re,
   input  logic signed [SW-1:0] c0_im,
   input  logic signed [SW-1:0] c1_re,
   input  logic signed [SW-1:0] c1_im,
   output logic                 det,
   output logic [IW-1:0]        det_idx
);
   localparam int SPAN  = 2 * LAG;
   localparam int TW    = 2 * SW + 1;
   localparam int PW    = acc_width(TW, LAG);
   localparam int RW    = acc_width(2 * SW, LAG);
   localparam int CPW   = PW + 1;
   localparam int CRW   = RW + 1;
   localparam int NCH   = 2;

   if (SW < 2) begin : g_bad_sw
      $error("SW must be at least 2");
   end
   if (LAG < 1) begin : g_bad_lag
      $error("LAG must be at least 1");
   end
   if (IW <= $clog2(SPAN)) begin : g_bad_iw
      $error("IW too narrow for the window span");
   end
   if (HW < 1) begin : g_bad_hw
      $error("HW must be at least 1");
   end

   chain_mode_e mode;
   assign mode = chain_mode_e'(dual_mode);

   logic accept;
   assign accept = in_valid && !clr;

   logic signed [SW-1:0] ch_re [NCH];
   logic signed [SW-1:0] ch_im [NCH];
   logic signed [PW-1:0] cp_re [NCH];
   logic signed [PW-1:0] cp_im [NCH];
   logic        [RW-1:0] cr    [NCH];

   assign ch_re[0] = c0_re;
   assign ch_im[0] = c0_im;
   assign ch_re[1] = c1_re;
   assign ch_im[1] = c1_im;

   for (genvar g = 0; g < NCH; g++) begin : g_chain
      adt_corr_chain #(.SW(SW), .HALF(LAG), .PW(PW), .RW(RW)) u_chain (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .shift (accept),
         .s_re  (ch_re[g]),
         .s_im  (ch_im[g]),
         .p_re  (cp_re[g]),
         .p_im  (cp_im[g]),
         .r_en  (cr[g])
      );
   end

   logic signed [CPW-1:0] sum_re, sum_im;
   logic        [CRW-1:0] sum_r;
   always_comb begin
      sum_re = CPW'(cp_re[0]);
      sum_im = CPW'(cp_im[0]);
      sum_r  = CRW'(cr[0]);
      if (mode == CHAIN_PAIR) begin
         sum_re = sum_re + CPW'(cp_re[1]);
         sum_im = sum_im + CPW'(cp_im[1]);
         sum_r  = sum_r + CRW'(cr[1]);
      end
   end

   // accepted-sample count (saturating) and fresh-sums flag
   logic [IW-1:0] smpl_cnt;
   logic          upd_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smpl_cnt <= '0;
         upd_q    <= 1'b0;
      end else if (clr) begin
         smpl_cnt <= '0;
         upd_q    <= 1'b0;
      end else begin
         upd_q <= accept;
         if (accept && (smpl_cnt != '1)) smpl_cnt <= smpl_cnt + 1'b1;
      end
   end

   logic          full;
   logic [IW-1:0] widx;
   assign full = smpl_cnt >= IW'(SPAN);
   assign widx = smpl_cnt - IW'(SPAN);

   adt_decide #(.CPW(CPW), .CRW(CRW), .IW(IW), .HW(HW)) u_decide (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .upd     (upd_q),
      .full    (full),
      .widx    (widx),
      .p_re    (sum_re),
      .p_im    (sum_im),
      .r_en    (sum_r),
      .hop     (hop),
      .det     (det),
      .det_idx (det_idx)
   );

endmodule

// File: rtl/adt_chk.sv
module adt_chk #(
   parameter int IW   = 16,
   parameter int SPAN = 160
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clr,
   input logic          det,
   input logic [IW-1:0] det_idx,
   input logic [IW-1:0] smpl_cnt,
   input logic          upd_q
);
   // R7
   det_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (det && !clr) |=> (det && $stable(det_idx)));

   // R1
   clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!det && det_idx == '0));

   // R3
   early_det_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(det) |-> (smpl_cnt >= IW'(SPAN)));

   // R2
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(det) |-> ((IW+1)'(det_idx) + (IW+1)'(SPAN) <= (IW+1)'(smpl_cnt)));

   // R8
   det_after_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(det) |-> $past(upd_q));

endmodule

bind acorr_pkt_det adt_chk #(.IW(IW), .SPAN(2 * LAG)) u_adt_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .det      (det),
   .det_idx  (det_idx),
   .smpl_cnt (smpl_cnt),
   .upd_q    (upd_q)
);

// File: tb/acorr_pkt_det_bench.sv
module acorr_pkt_det_bench;
   localparam int SW   = 12;
   localparam int LAG  = 80;
   localparam int IW   = 16;
   localparam int HW   = 8;
   localparam int SPAN = 2 * LAG;
   localparam int MAXN = 1024;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 clr = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 dual_mode = 1'b0;
   logic [HW-1:0]        hop = '0;
   logic signed [SW-1:0] c0_re = '0, c0_im = '0, c1_re = '0, c1_im = '0;
   logic                 det;
   logic [IW-1:0]        det_idx;

   always #10 clk = ~clk;

   acorr_pkt_det #(.SW(SW), .LAG(LAG), .IW(IW), .HW(HW)) u_acorr_pkt_det (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
      .dual_mode(dual_mode), .hop(hop),
      .c0_re(c0_re), .c0_im(c0_im), .c1_re(c1_re), .c1_im(c1_im),
      .det(det), .det_idx(det_idx)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int a0r [MAXN], a0i [MAXN], a1r [MAXN], a1i [MAXN];
   int rn, nd, rhop;
   bit rdone, rdual;
   string rtag;

   typedef struct { int idx; int due; string tag; } exp_t;
   exp_t sb [$];

   function automatic bit ref_hit(input int d);
      longint pr = 0, pi = 0, rr = 0;
      for (int m = 0; m < LAG; m++) begin
         pr += longint'(a0r[d+m]) * a0r[d+m+LAG] + longint'(a0i[d+m]) * a0i[d+m+LAG];
         pi += longint'(a0r[d+m]) * a0i[d+m+LAG] - longint'(a0i[d+m]) * a0r[d+m+LAG];
         rr += longint'(a0r[d+m+LAG]) * a0r[d+m+LAG] + longint'(a0i[d+m+LAG]) * a0i[d+m+LAG];
         if (rdual) begin
            pr += longint'(a1r[d+m]) * a1r[d+m+LAG] + longint'(a1i[d+m]) * a1i[d+m+LAG];
            pi += longint'(a1r[d+m]) * a1i[d+m+LAG] - longint'(a1i[d+m]) * a1r[d+m+LAG];
            rr += longint'(a1r[d+m+LAG]) * a1r[d+m+LAG] + longint'(a1i[d+m+LAG]) * a1i[d+m+LAG];
         end
      end
      return 2 * (pr * pr + pi * pi) > rr * rr;
   endfunction

   // driver: presents one sample (or an idle cycle) and pushes the expected detection
   task automatic put(input bit v, input int r0, input int i0, input int r1, input int i1);
      @(negedge clk);
      in_valid = v;
      c0_re = SW'(r0); c0_im = SW'(i0); c1_re = SW'(r1); c1_im = SW'(i1);
      if (v && rn < MAXN) begin
         a0r[rn] = r0; a0i[rn] = i0; a1r[rn] = r1; a1i[rn] = i1;
         rn++;
         if (!rdone && rn >= SPAN) begin
            if (rn - SPAN == nd) begin
               if (ref_hit(nd)) begin
                  sb.push_back('{nd, cyc + 2, rtag});
                  rdone = 1'b1;
               end else begin
                  nd += (rhop == 0) ? 1 : rhop;
               end
            end
         end
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // starts a case: clear pulse, then settings
   task automatic start_case(input bit dm, input int hp, input string tag);
      @(negedge clk);
      clr = 1'b1; in_valid = 1'b0;
      dual_mode = dm; hop = HW'(hp);
      @(negedge clk);
      clr = 1'b0;
      // R1: state after clear
      check(det == 1'b0, "R1 det after clr", det, 0);
      check(det_idx == '0, "R1 det_idx after clr", det_idx, 0);
      rn = 0; nd = 0; rdone = 1'b0; rdual = dm; rhop = hp; rtag = tag;
   endtask

   task automatic end_case(input string tag);
      repeat (4) idle();
      check(sb.size() == 0, {tag, " expected detection seen"}, sb.size(), 0);
      check(det == rdone, {tag, " final det"}, det, rdone);
   endtask

   // monitor: pops the scoreboard when det rises
   bit det_seen = 1'b0;
   always @(negedge clk) begin
      if (rst_n && det && !det_seen) begin
         if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected det rise", det_idx, -1);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(det_idx == IW'(e.idx), {e.tag, " det_idx (R2)"}, det_idx, e.idx);
            check(cyc == e.due, {e.tag, " det timing (R8)"}, cyc, e.due);
         end
      end
      det_seen = det;
   end

   // ---------------- stimulus helpers ----------------
   bit [31:0] st = 32'h1234_5677;
   function automatic int nz(input int amp);
      st = st ^ (st << 13);
      st = st ^ (st >> 17);
      st = st ^ (st << 5);
      return int'(st % (2 * amp + 1)) - amp;
   endfunction
   function automatic int per_re(input int n);
      return ((((n % 16) * 7) % 16) - 8) * 40;
   endfunction
   function automatic int per_im(input int n);
      return ((((n % 16) * 11 + 3) % 16) - 8) * 40;
   endfunction

   bit wd_hit = 1'b0;
   initial begin
      #(20 * 150000);
      wd_hit = 1'b1;
      check(1'b0, "watchdog", cyc, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(det == 1'b0, "R1 det in reset", det, 0);
      check(det_idx == '0, "R1 det_idx in reset", det_idx, 0);
      rst_n = 1'b1;

      // R3/R8: constant sample hits at the first window, no earlier
      start_case(1'b0, 4, "R3 constant");
      for (int n = 0; n < SPAN + 20; n++) put(1'b1, 300, -200, 0, 0);
      end_case("R3 constant");

      // R7: detection is sticky while more samples stream
      for (int n = 0; n < 30; n++) put(1'b1, nz(300), nz(300), 0, 0);
      repeat (3) idle();
      check(det == 1'b1, "R7 det held", det, 1);
      check(det_idx == '0, "R7 det_idx held", det_idx, 0);

      // R4: all-zero stream never hits (equality is a miss)
      start_case(1'b0, 3, "R4 zeros");
      for (int n = 0; n < 260; n++) put(1'b1, 0, 0, 0, 0);
      end_case("R4 zeros");

      // R5/R9/R6: noise then periodic, hop 8, gaps, chain 1 garbage in single mode
      start_case(1'b0, 8, "R5 hop8");
      for (int n = 0; n < 500; n++) begin
         if (n % 7 == 3) idle();   // R9: idle cycles in the stream
         if (n < 200) put(1'b1, nz(60), nz(60), nz(400), nz(400));
         else         put(1'b1, per_re(n) + nz(10), per_im(n) + nz(10), nz(400), nz(400));
      end
      end_case("R9 gaps");

      // R5: hop 0 behaves as 1
      start_case(1'b0, 0, "R5 hop0");
      for (int n = 0; n < 450; n++) begin
         if (n < 230) put(1'b1, nz(80), nz(80), 0, 0);
         else         put(1'b1, per_re(n), per_im(n), 0, 0);
      end
      end_case("R5 hop0");

      // R5: large hop
      start_case(1'b0, 37, "R5 hop37");
      for (int n = 0; n < 550; n++) begin
         if (n < 150) put(1'b1, nz(100), nz(100), 0, 0);
         else         put(1'b1, per_re(n) + nz(20), per_im(n), 0, 0);
      end
      end_case("R5 hop37");

      // R6: dual mode, pattern only on chain 1
      start_case(1'b1, 5, "R6 dual");
      for (int n = 0; n < 500; n++) begin
         if (n < 100) put(1'b1, nz(150), nz(150), nz(150), nz(150));
         else         put(1'b1, nz(150), nz(150), per_re(n), per_im(n));
      end
      end_case("R6 dual");

      // R6: same kind of stimulus in single mode, chain 1 has no effect
      start_case(1'b0, 5, "R6 single");
      for (int n = 0; n < 500; n++) begin
         if (n < 100) put(1'b1, nz(150), nz(150), nz(150), nz(150));
         else         put(1'b1, nz(150), nz(150), per_re(n), per_im(n));
      end
      end_case("R6 single");

      // R10: a sample presented with clr is discarded
      start_case(1'b0, 2, "R10 clr priority");
      @(negedge clk);
      clr = 1'b1; in_valid = 1'b1; c0_re = SW'(500); c0_im = SW'(500);
      @(negedge clk);
      clr = 1'b0; in_valid = 1'b0;
      for (int n = 0; n < SPAN + 5; n++) put(1'b1, -150, 250, 0, 0);
      end_case("R10 clr priority");

      if (!wd_hit) begin
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule